// File: doc/BRIEF.md
# USB Full-Speed Pin Adapter

This block joins a full-speed USB protocol engine to the pads or to an external transceiver. The engine offers one transmit stream: a data bit, a single-ended-zero flag and an output enable. The adapter places that stream on one of two transmit encodings, chosen at run time. The first encoding drives the two bus lines directly, as they appear on the cable. The second gives a transceiver a data bit and a separate single-ended-zero strobe.

The adapter also selects which line receives the 1.5k pull-up. It enables an external differential receiver only while the device is not suspended. It brings the receive pads into the core clock through synchronizers. One swap control exchanges the roles of the two physical lines, in both directions, so that the engine always sees logical D+ and D-.

Line states at the logical level are J (D+=1, D-=0), K (D+=0, D-=1) and SE0 (both 0). In the data/strobe encoding, J is data=1 with strobe=0, K is data=0 with strobe=0, and SE0 is strobe=1.

Top module: `usb_pin_adapter`

## Requirements
- R1: With `cfg_use_tx_d_se0_i`=0 and the enable high, one cycle after the inputs are sampled `pad_dp_o`/`pad_dn_o` carry the logical line state: J=1/0, K=0/1, SE0=0/0. In this mode `pad_d_o`/`pad_se0_o` rest at the idle J pair (1/0 before any swap).
- R2: With `cfg_use_tx_d_se0_i`=1 and the enable high, one cycle later `pad_se0_o` equals `core_tx_se0_i` and `pad_d_o` equals `core_tx_d_i`. In this mode `pad_dp_o`/`pad_dn_o` rest at idle J.
- R3: `tx_mode_d_se0_o` equals the value of `cfg_use_tx_d_se0_i` one cycle earlier. 0 means the bus-line pair is in use and 1 means the data/strobe pair is in use.
- R4: `pad_dp_en_o` and `pad_dn_en_o` both equal `core_tx_oe_i` one cycle earlier.
- R5: `pad_pullup_dp_o` = request AND NOT swap, and `pad_pullup_dn_o` = request AND swap, both registered one cycle. The two are never high together.
- R6: `rx_enable_o` equals `cfg_use_diff_rcvr_i` AND NOT `suspend_i` one cycle earlier.
- R7: While the enable is low, every transmit output holds idle J: dp/dn=1/0, d=1 and se0=0 before any swap.
- R8: With `cfg_pinflip_i`=1, the transmit values of R1, R2 and R7 leave with dp and dn exchanged and d inverted. `pad_se0_o` is not affected.
- R9: A receive pad level reaches the core outputs after two clock edges. With the swap set, `core_rx_dp_o` follows `pad_dn_i` and `core_rx_dn_o` follows `pad_dp_i`.
- R10: With `cfg_use_diff_rcvr_i`=1, `core_rx_d_o` is the synchronized `pad_d_i`, inverted when the swap is set. With it 0, `pad_d_i` is ignored and `core_rx_d_o` equals `core_rx_dp_o`.
- R11: During and after reset, before the first sampled input, the outputs read idle J on every transmit pin, enables off, pull-ups off, receiver off, mode 0, and core receive J (dp=1, dn=0, d=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_use_tx_d_se0_i | input | 1 | 1: data/strobe transmit encoding, 0: bus-line encoding |
| cfg_use_diff_rcvr_i | input | 1 | 1: take K/J from the external differential receiver |
| cfg_pinflip_i | input | 1 | Exchange the physical D+ and D- roles |
| core_tx_d_i | input | 1 | Transmit data from the engine, 1 = J |
| core_tx_se0_i | input | 1 | Transmit single-ended zero request |
| core_tx_oe_i | input | 1 | Transmit output enable |
| suspend_i | input | 1 | Device is suspended |
| pullup_req_i | input | 1 | Connect the pull-up |
| pad_dp_i | input | 1 | Receive pad D+ (asynchronous) |
| pad_dn_i | input | 1 | Receive pad D- (asynchronous) |
| pad_d_i | input | 1 | Differential receiver output (asynchronous) |
| core_rx_dp_o | output | 1 | Synchronized logical D+ |
| core_rx_dn_o | output | 1 | Synchronized logical D- |
| core_rx_d_o | output | 1 | Synchronized logical K/J data |
| pad_dp_o | output | 1 | Transmit D+ line |
| pad_dn_o | output | 1 | Transmit D- line |
| pad_d_o | output | 1 | Transmit data bit for a transceiver |
| pad_se0_o | output | 1 | Transmit single-ended-zero strobe |
| pad_dp_en_o | output | 1 | Output enable for D+ |
| pad_dn_en_o | output | 1 | Output enable for D- |
| pad_pullup_dp_o | output | 1 | Pull-up on the D+ pin |
| pad_pullup_dn_o | output | 1 | Pull-up on the D- pin |
| rx_enable_o | output | 1 | Differential receiver enable |
| tx_mode_d_se0_o | output | 1 | Active transmit encoding |

## Verification
Random cycles drive all eight combinations of the three configuration bits. Each cycle also gets a random J, K or SE0 symbol, a random enable, suspend and pull-up request, and random pad levels. This separates the swap and encoding choices from each other and from the idle override. Directed cases then cover four points. First, the reset values. Second, the one-cycle transmit latency and the two-edge receive latency, each sampled one cycle early and on time. Third, an SE0 in each encoding. Fourth, a toggle of the receiver pad while the receiver is not selected, which must leave the core data unchanged.

// File: rtl/usb_pin_pkg.sv
package usb_pin_pkg;

    // Transmit pin group at the pad edge.
    typedef struct packed {
        logic dp;
        logic dn;
        logic d;
        logic se0;
    } tx_lines_t;

    // Receive pin group.
    typedef struct packed {
        logic dp;
        logic dn;
        logic d;
    } rx_lines_t;

    localparam tx_lines_t TxIdleJ = '{dp: 1'b1, dn: 1'b0, d: 1'b1, se0: 1'b0};
    localparam rx_lines_t RxIdleJ = '{dp: 1'b1, dn: 1'b0, d: 1'b1};

    // Exchange the physical line roles; the data bit flips polarity with them.
    function automatic tx_lines_t swap_tx(tx_lines_t l, logic flip);
        tx_lines_t r;
        r = l;
        if (flip) begin
            r.dp = l.dn;
            r.dn = l.dp;
            r.d  = ~l.d;
        end
        return r;
    endfunction

endpackage

// File: rtl/usb_pin_tx.sv
module usb_pin_tx
    import usb_pin_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      mode_d_se0_i,
    input  logic      flip_i,
    input  logic      d_i,
    input  logic      se0_i,
    input  logic      oe_i,
    output tx_lines_t lines_o,
    output logic      oe_o,
    output logic      mode_o
);

    typedef struct packed {
        tx_lines_t lines;
        logic      oe;
        logic      mode;
    } tx_state_t;

    localparam tx_state_t TxReset = '{lines: TxIdleJ, oe: 1'b0, mode: 1'b0};

    tx_state_t st_d, st_q;
    tx_lines_t logical;

    always_comb begin
        logical = TxIdleJ;
        if (oe_i) begin
            if (mode_d_se0_i) begin
                logical.d   = d_i;
                logical.se0 = se0_i;
            end else begin
                logical.dp = ~se0_i & d_i;
                logical.dn = ~se0_i & ~d_i;
            end
        end
        st_d.lines = swap_tx(logical, flip_i);
        st_d.oe    = oe_i;
        st_d.mode  = mode_d_se0_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= TxReset;
        else         st_q <= st_d;
    end

    assign lines_o = st_q.lines;
    assign oe_o    = st_q.oe;
    assign mode_o  = st_q.mode;

endmodule

// File: rtl/usb_pin_ctl.sv
module usb_pin_ctl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic flip_i,
    input  logic pullup_req_i,
    input  logic use_diff_i,
    input  logic suspend_i,
    output logic pullup_dp_o,
    output logic pullup_dn_o,
    output logic rx_enable_o
);

    typedef struct packed {
        logic pu_dp;
        logic pu_dn;
        logic rx_en;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d.pu_dp = pullup_req_i & ~flip_i;
        st_d.pu_dn = pullup_req_i & flip_i;
        st_d.rx_en = use_diff_i & ~suspend_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pullup_dp_o = st_q.pu_dp;
    assign pullup_dn_o = st_q.pu_dn;
    assign rx_enable_o = st_q.rx_en;

endmodule

// File: rtl/usb_pin_rx.sv
module usb_pin_rx
    import usb_pin_pkg::*;
#(
    parameter int unsigned Stages = 2
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  rx_lines_t pads_i,
    input  logic      flip_i,
    input  logic      use_diff_i,
    output logic      rx_dp_o,
    output logic      rx_dn_o,
    output logic      rx_d_o
);

    localparam int unsigned Last = Stages - 1;

    rx_lines_t sync_d [Stages];
    rx_lines_t sync_q [Stages];

    // Synchronizer chain: stage 0 samples the pads, each later stage the one before.
    for (genvar s = 0; s < Stages; s++) begin : g_sync
        if (s == 0) begin : g_first
            always_comb sync_d[s] = pads_i;
        end else begin : g_next
            always_comb sync_d[s] = sync_q[s-1];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q[s] <= RxIdleJ;
            else         sync_q[s] <= sync_d[s];
        end
    end

    rx_lines_t settled;
    logic      logical_dp;

    always_comb begin
        settled    = sync_q[Last];
        logical_dp = flip_i ? settled.dn : settled.dp;
        rx_dp_o    = logical_dp;
        rx_dn_o    = flip_i ? settled.dp : settled.dn;
        rx_d_o     = use_diff_i ? (settled.d ^ flip_i) : logical_dp;
    end

endmodule

// File: rtl/usb_pin_adapter.sv
module usb_pin_adapter
    import usb_pin_pkg::*;
#(
    parameter int unsigned SyncStages = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cfg_use_tx_d_se0_i,
    input  logic cfg_use_diff_rcvr_i,
    input  logic cfg_pinflip_i,
    input  logic core_tx_d_i,
    input  logic core_tx_se0_i,
    input  logic core_tx_oe_i,
    input  logic suspend_i,
    input  logic pullup_req_i,
    input  logic pad_dp_i,
    input  logic pad_dn_i,
    input  logic pad_d_i,
    output logic core_rx_dp_o,
    output logic core_rx_dn_o,
    output logic core_rx_d_o,
    output logic pad_dp_o,
    output logic pad_dn_o,
    output logic pad_d_o,
    output logic pad_se0_o,
    output logic pad_dp_en_o,
    output logic pad_dn_en_o,
    output logic pad_pullup_dp_o,
    output logic pad_pullup_dn_o,
    output logic rx_enable_o,
    output logic tx_mode_d_se0_o
);

    tx_lines_t tx_lines;
    logic      tx_oe;
    rx_lines_t rx_pads;

    usb_pin_tx u_tx (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mode_d_se0_i (cfg_use_tx_d_se0_i),
        .flip_i       (cfg_pinflip_i),
        .d_i          (core_tx_d_i),
        .se0_i        (core_tx_se0_i),
        .oe_i         (core_tx_oe_i),
        .lines_o      (tx_lines),
        .oe_o         (tx_oe),
        .mode_o       (tx_mode_d_se0_o)
    );

    usb_pin_ctl u_ctl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .flip_i       (cfg_pinflip_i),
        .pullup_req_i (pullup_req_i),
        .use_diff_i   (cfg_use_diff_rcvr_i),
        .suspend_i    (suspend_i),
        .pullup_dp_o  (pad_pullup_dp_o),
        .pullup_dn_o  (pad_pullup_dn_o),
        .rx_enable_o  (rx_enable_o)
    );

    assign rx_pads = '{dp: pad_dp_i, dn: pad_dn_i, d: pad_d_i};

    usb_pin_rx #(.Stages(SyncStages)) u_rx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pads_i     (rx_pads),
        .flip_i     (cfg_pinflip_i),
        .use_diff_i (cfg_use_diff_rcvr_i),
        .rx_dp_o    (core_rx_dp_o),
        .rx_dn_o    (core_rx_dn_o),
        .rx_d_o     (core_rx_d_o)
    );

    assign pad_dp_o    = tx_lines.dp;
    assign pad_dn_o    = tx_lines.dn;
    assign pad_d_o     = tx_lines.d;
    assign pad_se0_o   = tx_lines.se0;
    assign pad_dp_en_o = tx_oe;
    assign pad_dn_en_o = tx_oe;

endmodule

// File: rtl/usb_pin_adapter_chk.sv
module usb_pin_adapter_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic cfg_use_tx_d_se0_i,
    input logic cfg_use_diff_rcvr_i,
    input logic core_tx_se0_i,
    input logic core_tx_oe_i,
    input logic suspend_i,
    input logic pad_dp_o,
    input logic pad_dn_o,
    input logic pad_se0_o,
    input logic pad_dp_en_o,
    input logic pad_dn_en_o,
    input logic pad_pullup_dp_o,
    input logic pad_pullup_dn_o,
    input logic rx_enable_o,
    input logic tx_mode_d_se0_o
);

    a_r1_bus_se0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_tx_oe_i && !cfg_use_tx_d_se0_i && core_tx_se0_i) |=> (!pad_dp_o && !pad_dn_o));

    a_r2_strobe_se0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_tx_oe_i && cfg_use_tx_d_se0_i && core_tx_se0_i) |=> pad_se0_o);

    a_r3_mode_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (tx_mode_d_se0_o == $past(cfg_use_tx_d_se0_i)));

    a_r4_enables_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (pad_dp_en_o == $past(core_tx_oe_i) && pad_dn_en_o == $past(core_tx_oe_i)));

    a_r5_one_pullup: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({pad_pullup_dp_o, pad_pullup_dn_o}));

    a_r6_rx_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (rx_enable_o == ($past(cfg_use_diff_rcvr_i) && !$past(suspend_i))));

    a_r7_idle_j: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !core_tx_oe_i |=> (pad_dp_o != pad_dn_o && !pad_se0_o));

endmodule

bind usb_pin_adapter usb_pin_adapter_chk u_chk (.*);

// File: tb/tb_usb_pin_adapter.sv
module tb_usb_pin_adapter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic use_dse0 = 0, use_diff = 0, flip = 0;
    logic tx_d = 1, tx_se0 = 0, tx_oe = 0, susp = 0, pu_req = 0;
    logic in_dp = 1, in_dn = 0, in_d = 1;
    logic rx_dp, rx_dn, rx_d, o_dp, o_dn, o_d, o_se0, en_dp, en_dn, pu_dp, pu_dn, rx_en, mode;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #10 clk = ~clk;

    usb_pin_adapter dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_use_tx_d_se0_i(use_dse0), .cfg_use_diff_rcvr_i(use_diff), .cfg_pinflip_i(flip),
        .core_tx_d_i(tx_d), .core_tx_se0_i(tx_se0), .core_tx_oe_i(tx_oe),
        .suspend_i(susp), .pullup_req_i(pu_req),
        .pad_dp_i(in_dp), .pad_dn_i(in_dn), .pad_d_i(in_d),
        .core_rx_dp_o(rx_dp), .core_rx_dn_o(rx_dn), .core_rx_d_o(rx_d),
        .pad_dp_o(o_dp), .pad_dn_o(o_dn), .pad_d_o(o_d), .pad_se0_o(o_se0),
        .pad_dp_en_o(en_dp), .pad_dn_en_o(en_dn),
        .pad_pullup_dp_o(pu_dp), .pad_pullup_dn_o(pu_dn),
        .rx_enable_o(rx_en), .tx_mode_d_se0_o(mode)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Expected transmit pins {dp,dn,d,se0} from the requirements (R1, R2, R7, R8).
    function automatic logic [3:0] exp_tx(logic m, logic f, logic d, logic s, logic oe);
        logic dp, dn, dd, se;
        dp = 1; dn = 0; dd = 1; se = 0;
        if (oe && !m) begin dp = !s && d; dn = !s && !d; end
        if (oe && m)  begin dd = d; se = s; end
        if (f) return {dn, dp, !dd, se};
        return {dp, dn, dd, se};
    endfunction

    task automatic check_tx(string req);
        logic [3:0] e;
        e = exp_tx(use_dse0, flip, tx_d, tx_se0, tx_oe);
        chk(req, "dp", o_dp, e[3]);
        chk(req, "dn", o_dn, e[2]);
        chk(req, "d", o_d, e[1]);
        chk(req, "se0", o_se0, e[0]);
    endtask

    task automatic check_ctl();
        chk("R3", "mode", mode, use_dse0);
        chk("R4", "dp_en", en_dp, tx_oe);
        chk("R4", "dn_en", en_dn, tx_oe);
        chk("R5", "pullup_dp", pu_dp, pu_req & ~flip);
        chk("R5", "pullup_dn", pu_dn, pu_req & flip);
        chk("R6", "rx_enable", rx_en, use_diff & ~susp);
    endtask

    task automatic check_rx(string req);
        logic ldp;
        ldp = flip ? in_dn : in_dp;
        chk(req, "rx_dp", rx_dp, ldp);
        chk(req, "rx_dn", rx_dn, flip ? in_dp : in_dn);
        chk("R10", "rx_d", rx_d, use_diff ? (in_d ^ flip) : ldp);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h1a2b3c);
        // R11: reset values
        #25;
        chk("R11", "dp", o_dp, 1); chk("R11", "dn", o_dn, 0);
        chk("R11", "d", o_d, 1);   chk("R11", "se0", o_se0, 0);
        chk("R11", "en", en_dp, 0); chk("R11", "pullups", pu_dp | pu_dn, 0);
        chk("R11", "rx_en", rx_en, 0); chk("R11", "mode", mode, 0);
        chk("R11", "rx_dp", rx_dp, 1); chk("R11", "rx_dn", rx_dn, 0); chk("R11", "rx_d", rx_d, 1);
        @(negedge clk); rst_n = 1;
        @(negedge clk);

        // R1: K symbol, one-cycle latency
        tx_oe = 1; tx_d = 0; tx_se0 = 0;
        @(posedge clk); #1;
        @(negedge clk); check_tx("R1");
        tx_se0 = 1; @(negedge clk); check_tx("R1");
        // R2: strobe encoding with SE0, then J
        use_dse0 = 1; @(negedge clk); check_tx("R2"); chk("R3", "mode", mode, 1);
        tx_se0 = 0; tx_d = 1; @(negedge clk); check_tx("R2");
        // R8: swap on strobe encoding
        flip = 1; tx_d = 0; @(negedge clk); check_tx("R8");
        // R7: idle with swap
        tx_oe = 0; @(negedge clk); check_tx("R7"); check_ctl();

        // R9: two-edge receive latency with swap
        flip = 1; use_diff = 0; in_dp = 1; in_dn = 0;
        @(negedge clk);
        in_dp = 0; in_dn = 1;
        @(negedge clk);
        chk("R9", "rx_dp early", rx_dp, 0);
        @(negedge clk);
        chk("R9", "rx_dp", rx_dp, 1); chk("R9", "rx_dn", rx_dn, 0);
        // R10: pad d ignored when receiver not selected
        in_d = 0; @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R10", "rx_d ignored", rx_d, 1);
        in_d = 1; @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R10", "rx_d ignored", rx_d, 1);

        // Random mix across all configurations
        for (int i = 0; i < 400; i++) begin
            logic [1:0] sym;
            @(negedge clk);
            {use_dse0, use_diff, flip} = 3'($urandom);
            sym = 2'($urandom_range(0, 2));
            tx_d = (sym == 0); tx_se0 = (sym == 2);
            tx_oe = ($urandom_range(0, 3) != 0);
            susp = 1'($urandom); pu_req = 1'($urandom);
            {in_dp, in_dn, in_d} = 3'($urandom);
            @(negedge clk); @(negedge clk);
            check_tx(tx_oe ? (use_dse0 ? "R2" : "R1") : "R7");
            check_ctl();
            check_rx("R9");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule